// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is the counting core of a real-time clock. A 100 Hz enable pulse advances a chain of BCD counters: hundredths of a second, seconds, minutes, hours, weekday, date, month and year. The day count of each month follows the month and the year, so February has 29 days in leap years. Hours count in either a 24-hour or a 12-hour format with an afternoon flag. Bit 7 of the hours register selects the format.

The eight 8-bit registers are packed into one 64-bit word. Register k sits in bits 8k+7 to 8k:
- 0: hundredths
- 1: seconds
- 2: minutes
- 3: hours
- 4: day
- 5: date
- 6: month
- 7: year

A serial access front end reads the whole word at once through the snapshot output. It writes all eight registers together on one clock edge through the load port.

The day register also carries two control bits. Bit 5 is a halt bit that stops all counting while it is 1. Bit 4 is a reset-enable bit, which is held here for the access front end.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the snapshot reads 64'h00_01_01_31_00_00_00_00. This is 24-hour mode at 00:00:00.00, weekday 1, date 01, month 01, year 00, with day bits 5 and 4 both set.
- R2: With halt clear, each cycle with tick_i high advances the hundredths (BCD 00 to 99). The step after 99 gives 00 and a carry into seconds. With tick_i low, nothing changes.
- R3: Seconds and minutes count in BCD from 00 to 59. From 59, a carry gives 00 and a carry into the next field.
- R4: Hours bit 7 = 0 selects 24-hour mode. Hours bits 5:0 count in BCD from 00 to 23, so bit 5 is set for hours 20 to 23. A carry from 23 gives 00 and advances the weekday and the date.
- R5: Hours bit 7 = 1 selects 12-hour mode. Bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag (1 = PM). The sequence runs 12, 01, ..., 11. The flag toggles on the step from 11 to 12. The step from 11 PM to 12 AM advances the weekday and the date.
- R6: The weekday (day bits 2:0) counts from 1 to 7 and wraps to 1.
- R7: The date wraps to 01 after the last day of the month and advances the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the year is divisible by 4, and on 28 otherwise.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R9: While day bit 5 is 1, ticks change nothing.
- R10: Day bits 5 and 4 change only by a load. Counting, including a weekday rollover, leaves them as they were.
- R11: A load replaces all eight registers on one edge. A tick in the same cycle is dropped.
- R12: Unused bits always read 0 whatever is loaded:
  - seconds and minutes bit 7
  - hours bit 6
  - day bits 7, 6 and 3
  - date bits 7:6
  - month bits 7:5

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 100 Hz count enable, one cycle wide |
| load_i | input | 1 | Write all eight registers from load_data_i |
| load_data_i | input | 64 | Register image to load, register k in bits 8k+7:8k |
| snap_o | output | 64 | Current register image, same packing |

## Verification
The hardest states to reach from the ports are the long cascades, such as 11 PM on the last day of a leap February or the final moment of year 99. Reaching them by ticking alone would take millions of cycles. The bench therefore loads a register image one tick before each boundary, then issues a single tick and compares the whole 64-bit snapshot. A table of such image pairs covers each wrap point. Directed steps cover the halt bit, the dropped tick during a load, and the masking of unused bits.

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        load_i,
  input  logic [63:0] load_data_i,
  output logic [63:0] snap_o
);

  localparam logic [63:0] KEEP_MASK = 64'hFF_1F_3F_37_BF_7F_7F_FF;
  localparam logic [63:0] RESET_IMG = 64'h00_01_01_31_00_00_00_00;

  logic [7:0] hund, sec, mins, hr, day, date, mon, yr;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction

  wire       run    = tick_i & ~day[5];
  wire       mode12 = hr[7];
  wire [4:0] h12    = hr[4:0];

  wire c_sec  = hund == 8'h99;
  wire c_min  = c_sec & (sec == 8'h59);
  wire c_hr   = c_min & (mins == 8'h59);
  wire c_day  = c_hr & (mode12 ? (h12 == 5'h11 && hr[5]) : (hr[5:0] == 6'h23));
  wire c_mon  = c_day & (date == last_day(mon, yr));
  wire c_yr   = c_mon & (mon == 8'h12);

  logic [7:0] hr_next;
  logic [7:0] inc5, inc6;
  assign inc5 = bcd_inc({3'b000, h12});
  assign inc6 = bcd_inc({2'b00, hr[5:0]});

  always_comb begin
    if (mode12) begin
      if (h12 == 5'h12)      hr_next = {1'b1, 1'b0, hr[5], 5'h01};
      else if (h12 == 5'h11) hr_next = {1'b1, 1'b0, ~hr[5], 5'h12};
      else                   hr_next = {1'b1, 1'b0, hr[5], inc5[4:0]};
    end else begin
      hr_next = (hr[5:0] == 6'h23) ? 8'h00 : {2'b00, inc6[5:0]};
    end
  end

  wire [63:0] load_img = load_data_i & KEEP_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {yr, mon, date, day, hr, mins, sec, hund} <= RESET_IMG;
    end else if (load_i) begin
      {yr, mon, date, day, hr, mins, sec, hund} <= load_img;
    end else if (run) begin
      hund <= c_sec ? 8'h00 : bcd_inc(hund);
      if (c_sec) sec  <= (sec == 8'h59) ? 8'h00 : bcd_inc(sec);
      if (c_min) mins <= (mins == 8'h59) ? 8'h00 : bcd_inc(mins);
      if (c_hr)  hr   <= hr_next;
      if (c_day) begin
        day[2:0] <= (day[2:0] == 3'd7) ? 3'd1 : day[2:0] + 3'd1;
        date     <= (date == last_day(mon, yr)) ? 8'h01 : bcd_inc(date);
      end
      if (c_mon) mon <= (mon == 8'h12) ? 8'h01 : bcd_inc(mon);
      if (c_yr)  yr  <= (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
    end
  end

  assign snap_o = {yr, mon, date, day, hr, mins, sec, hund};

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> snap_o == ($past(load_data_i) & KEEP_MASK)); // R11
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && snap_o[37]) |=> $stable(snap_o)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(snap_o)); // R2
  AST_CTL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> snap_o[37:36] == $past(snap_o[37:36])); // R10
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_o & ~KEEP_MASK) == 64'd0); // R12

endmodule

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // image before one tick, image after it; register k at bits 8k+7:8k
  localparam logic [63:0] V_IN [NV] = '{
    64'h24_03_15_03_10_20_30_99, // R2
    64'h24_03_15_03_10_20_30_09, // R2
    64'h24_03_15_03_10_20_59_99, // R3
    64'h24_03_15_03_10_59_59_99, // R3
    64'h24_03_15_03_19_59_59_99, // R4
    64'h24_03_15_13_23_59_59_99, // R4 R10
    64'h24_03_15_03_91_59_59_99, // R5
    64'h24_03_15_03_B2_59_59_99, // R5
    64'h24_03_15_03_B1_59_59_99, // R5
    64'h24_03_15_03_92_59_59_99, // R5
    64'h24_03_15_07_23_59_59_99, // R6
    64'h24_04_30_02_23_59_59_99, // R7
    64'h23_02_28_02_23_59_59_99, // R7
    64'h24_02_28_02_23_59_59_99, // R7
    64'h24_02_29_02_23_59_59_99, // R7
    64'h24_01_31_02_23_59_59_99, // R7
    64'h00_02_28_02_23_59_59_99, // R7
    64'h26_02_28_02_23_59_59_99, // R7
    64'h12_02_28_02_23_59_59_99, // R7
    64'h24_11_30_02_23_59_59_99, // R7
    64'h24_12_31_02_23_59_59_99, // R8
    64'h99_12_31_02_23_59_59_99  // R8
  };
  localparam logic [63:0] V_EXP [NV] = '{
    64'h24_03_15_03_10_20_31_00,
    64'h24_03_15_03_10_20_30_10,
    64'h24_03_15_03_10_21_00_00,
    64'h24_03_15_03_11_00_00_00,
    64'h24_03_15_03_20_00_00_00,
    64'h24_03_16_14_00_00_00_00,
    64'h24_03_15_03_B2_00_00_00,
    64'h24_03_15_03_A1_00_00_00,
    64'h24_03_16_04_92_00_00_00,
    64'h24_03_15_03_81_00_00_00,
    64'h24_03_16_01_00_00_00_00,
    64'h24_05_01_03_00_00_00_00,
    64'h23_03_01_03_00_00_00_00,
    64'h24_02_29_03_00_00_00_00,
    64'h24_03_01_03_00_00_00_00,
    64'h24_02_01_03_00_00_00_00,
    64'h00_02_29_03_00_00_00_00,
    64'h26_03_01_03_00_00_00_00,
    64'h12_02_29_03_00_00_00_00,
    64'h24_12_01_03_00_00_00_00,
    64'h25_01_01_03_00_00_00_00,
    64'h00_01_01_03_00_00_00_00
  };
  localparam int V_REQ [NV] = '{2,2,3,3,4,4,5,5,5,5,6,7,7,7,7,7,7,7,7,7,8,8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic load_i = 1'b0;
  logic [63:0] load_data_i = '0;
  logic [63:0] snap_o;
  int n_run = 0;
  int n_fail = 0;

  bcd_calendar_core i_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
    .load_data_i(load_data_i), .snap_o(snap_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] exp);
    n_run++;
    if (snap_o !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, snap_o, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] img);
    load_data_i = img;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 64'h00_01_01_31_00_00_00_00);
    // R9 R10: halt bit set out of reset, ticks do nothing
    do_ticks(5);
    check("R9", 64'h00_01_01_31_00_00_00_00);

    for (int i = 0; i < NV; i++) begin
      do_load(V_IN[i]);
      do_ticks(1);
      n_run++;
      if (snap_o !== V_EXP[i]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: got %h expected %h", V_REQ[i], i, snap_o, V_EXP[i]);
      end
    end

    // R2: 150 ticks from zero, then idle cycles change nothing
    do_load(64'h24_03_15_03_00_00_00_00);
    do_ticks(150);
    repeat (4) @(negedge clk);
    check("R2", 64'h24_03_15_03_00_00_01_50);

    // R9: halt with bit 5 set while running state is otherwise valid
    do_load(64'h24_03_15_23_10_20_30_40);
    do_ticks(7);
    check("R9", 64'h24_03_15_23_10_20_30_40);

    // R11: tick in the load cycle is dropped
    load_data_i = 64'h24_03_15_03_10_20_30_40;
    load_i = 1'b1;
    tick_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    tick_i = 1'b0;
    check("R11", 64'h24_03_15_03_10_20_30_40);
    do_ticks(1);
    check("R11", 64'h24_03_15_03_10_20_30_41);

    // R12: unused bits read zero after loading all ones (halt bit set)
    do_load({64{1'b1}});
    check("R12", 64'hFF_1F_3F_37_BF_7F_7F_FF);
    do_ticks(3);
    check("R12", 64'hFF_1F_3F_37_BF_7F_7F_FF);

    // R10: reset-enable bit kept across rollovers with counting active
    do_load(64'h24_03_15_17_23_59_59_99);
    do_ticks(1);
    check("R10", 64'h24_03_16_11_00_00_00_00);

    // R1: reset again restores the reset image
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", 64'h00_01_01_31_00_00_00_00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule